// File: doc/BRIEF.md
# Programmable Pulse Cycle Generator

This block produces repeating pulse cycles for a test-signal source. A cycle lasts a programmed number of interval units. Inside each cycle it places a pulse whose width is a programmed number of width units. The pulse can start when the cycle starts (single), after a programmed delay counted in interval units (delayed), or at both points (double). Each cycle opens with a short marker on a separate output so that other equipment can line up with it. The timebase comes from outside as a vector of tick strobes, one per range. A range code selects which strobe clocks the interval and delay counters, and a second range code selects the strobe for the width and the marker.

Cycles can run without a trigger, start once on each rising edge of an external trigger, or repeat for as long as that input is held high as a gate. Three waveform variants replace the pulse with a square wave: one toggles its level at every cycle start, one toggles on every core clock edge (half the core rate), and one follows the core clock itself. The run bit enables everything. When run is cleared, all outputs return to low and the block goes idle. All control inputs are plain levels with no handshake, and the trigger is assumed to be synchronous to the core clock.

Top module: `pulse_cycle_gen`

## Requirements
- R1: After reset, `pulse_o`, `mark_o` and `busy_o` are low.
- R2: In pulse waveform (`wave_i` = 00) with single pulse selected (both `delayed_i` and `double_i` low), a cycle start raises `pulse_o` at the first clock edge after the start condition. The pulse stays high for `pw_mult_i` width units. Cycles restart every `pri_mult_i` interval units.
- R3: With `delayed_i` high and `double_i` low, the pulse rises `dly_mult_i` interval units after the cycle start, lasts `pw_mult_i` width units, and nothing is output at the cycle start.
- R4: With `double_i` high, a primary pulse starts with the cycle and a second pulse of the same width starts `dly_mult_i` interval units later. This holds whatever the value of `delayed_i`.
- R5: With `free_i` high, cycles repeat back to back and the trigger input has no effect. Every cycle start raises `mark_o` for one width unit.
- R6: With `free_i` and `gated_i` low, a rising edge on `trig_i` starts one cycle at the next clock edge. `busy_o` is high for `pri_mult_i` interval units, and then the block is idle.
- R7: A rising edge on `trig_i` that arrives while a cycle is still counting its interval is ignored. This holds even after the pulse has ended.
- R8: With `gated_i` high, a new cycle follows whenever `trig_i` is high at the end of an interval. When the gate is low at that point, the current cycle completes and output stops.
- R9: With `wave_i` = 01, the output level toggles at each cycle start, giving a period of twice the interval. The width and delay settings have no effect. When the gate stops the cycles, the level holds.
- R10: With `wave_i` = 10, `pulse_o` toggles on every clock edge. With `wave_i` = 11, `pulse_o` is high during the high phase of the clock and low during its low phase. Both modes ignore the interval setting and the trigger. `busy_o` is high and `mark_o` is low.
- R11: While `run_i` is low, no activity appears. Clearing `run_i` drives all three outputs low at the next clock edge.
- R12: Bit n of `tick_i` is the timebase for range code n. The width counter and the marker advance only on ticks of the range selected by `pw_rng_i`. The interval and delay counters advance only on ticks of the range selected by `pri_rng_i`. Codes of `NUM_RANGES` and above select no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Master enable |
| wave_i | input | 2 | Waveform: 00 pulse, 01 square per interval, 10 half-rate square, 11 full-rate square |
| free_i | input | 1 | Free-running cycles |
| gated_i | input | 1 | Trigger acts as a level gate rather than an edge |
| delayed_i | input | 1 | Pulse starts after the delay |
| double_i | input | 1 | Pulse at start and after the delay |
| pri_rng_i | input | RSEL_W | Range code for the interval and delay |
| pw_rng_i | input | RSEL_W | Range code for the width and the marker |
| pri_mult_i | input | MULT_W | Interval multiplier |
| dly_mult_i | input | MULT_W | Delay multiplier |
| pw_mult_i | input | MULT_W | Width multiplier |
| tick_i | input | NUM_RANGES | Timebase strobes, one per range |
| trig_i | input | 1 | External trigger or gate |
| pulse_o | output | 1 | Logic pulse or square wave |
| mark_o | output | 1 | Cycle-start marker |
| busy_o | output | 1 | Cycle in progress or fixed square running |

## Verification
Every registered result is due at the first rising clock edge after the stimulus that causes it. The bench applies inputs on the falling edge, so edge index 0 is the next rising edge. A cycle start shows the marker and the primary pulse at index 0, a delayed pulse at index `dly_mult_i`, and the next cycle at index `pri_mult_i` when all ticks are high. The driver pushes one expected sample for each rising edge, starting at index 0. The monitor pops one sample a quarter period after each rising edge and compares it with the outputs. For gate and trigger changes made in mid-stream, the driver counts falling edges so that the change lands on a known index. The full-rate mode also gets one sample in the low clock phase.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  typedef enum logic [1:0] {
    WAVE_PULSE  = 2'b00,
    WAVE_SQUARE = 2'b01,
    WAVE_HALF   = 2'b10,
    WAVE_FULL   = 2'b11
  } wave_e;
endpackage

// File: rtl/pcg_start_qual.sv
module pcg_start_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic free_i,
  input  logic gated_i,
  input  logic trig_i,
  output logic want_o
);
  logic trig_d_q;
  logic rise_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_d_q <= 1'b0;
    else         trig_d_q <= trig_i;
  end

  assign rise_w = trig_i & ~trig_d_q;
  // a cycle is wanted when the selected trigger regime asks for one
  assign want_o = run_i & (free_i | (gated_i ? trig_i : rise_w));
endmodule

// File: rtl/pcg_interval_seq.sv
module pcg_interval_seq #(
  parameter int MULT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              want_i,
  input  logic              tick_i,
  input  logic [MULT_W-1:0] pri_mult_i,
  input  logic [MULT_W-1:0] dly_mult_i,
  input  logic              dly_en_i,
  output logic              start_o,
  output logic              active_o,
  output logic              dly_hit_o
);
  localparam logic [MULT_W:0] ONE = (MULT_W+1)'(1);

  logic              active_q;
  logic [MULT_W-1:0] cnt_q;
  logic [MULT_W:0]   nxt_w;
  logic              end_w;

  assign nxt_w     = {1'b0, cnt_q} + ONE;
  assign end_w     = active_q & tick_i & (nxt_w >= {1'b0, pri_mult_i});
  // holdoff: a new cycle only from idle or exactly at the interval end
  assign start_o   = en_i & want_i & (~active_q | end_w);
  assign dly_hit_o = en_i & active_q & tick_i & dly_en_i & ~end_w &
                     (nxt_w == {1'b0, dly_mult_i});
  assign active_o  = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!en_i) begin
      active_q <= 1'b0;
    end else if (start_o) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (end_w) begin
      active_q <= 1'b0;
    end else if (active_q && tick_i) begin
      cnt_q    <= nxt_w[MULT_W-1:0];
    end
  end

  assert_run_clear_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_q);
  assert_holdoff_no_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && active_q && !tick_i) |=> (active_q && $stable(cnt_q)));
endmodule

// File: rtl/pcg_pulse_shaper.sv
module pcg_pulse_shaper #(
  parameter int MULT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pulse_en_i,
  input  logic              mark_en_i,
  input  logic              start_i,
  input  logic              prim_en_i,
  input  logic              dly_hit_i,
  input  logic              tick_i,
  input  logic [MULT_W-1:0] pw_mult_i,
  output logic              pulse_o,
  output logic              mark_o
);
  localparam logic [MULT_W:0] ONE = (MULT_W+1)'(1);

  logic              pulse_q;
  logic              mark_q;
  logic [MULT_W-1:0] cnt_q;
  logic [MULT_W:0]   nxt_w;
  logic              launch_w;

  assign nxt_w    = {1'b0, cnt_q} + ONE;
  assign launch_w = (start_i & prim_en_i) | dly_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!pulse_en_i) begin
      pulse_q <= 1'b0;
    end else if (launch_w) begin
      pulse_q <= 1'b1;
      cnt_q   <= '0;
    end else if (pulse_q && tick_i) begin
      if (nxt_w >= {1'b0, pw_mult_i}) pulse_q <= 1'b0;
      else                            cnt_q   <= nxt_w[MULT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mark_q <= 1'b0;
    else if (!mark_en_i) mark_q <= 1'b0;
    else if (start_i)    mark_q <= 1'b1;
    else if (tick_i)     mark_q <= 1'b0;
  end

  assign pulse_o = pulse_q;
  assign mark_o  = mark_q;

  assert_mark_at_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_en_i && start_i) |=> mark_q);
  assert_width_needs_tick_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_en_i && pulse_q && !tick_i) |=> pulse_q);
endmodule

// File: rtl/pcg_wave_out.sv
module pcg_wave_out
  import pcg_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  run_i,
  input  wave_e wave_i,
  input  logic  start_i,
  input  logic  pulse_i,
  output logic  fixed_on_o,
  output logic  pulse_o
);
  logic sq_q;
  logic half_q;
  logic fixed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q    <= 1'b0;
      half_q  <= 1'b0;
      fixed_q <= 1'b0;
    end else if (!run_i) begin
      sq_q    <= 1'b0;
      half_q  <= 1'b0;
      fixed_q <= 1'b0;
    end else begin
      fixed_q <= wave_i[1];
      if (wave_i == WAVE_SQUARE && start_i) sq_q <= ~sq_q;
      if (wave_i == WAVE_HALF) half_q <= ~half_q;
      else                     half_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (wave_i)
      WAVE_PULSE:  pulse_o = pulse_i;
      WAVE_SQUARE: pulse_o = sq_q;
      WAVE_HALF:   pulse_o = half_q;
      default:     pulse_o = fixed_q & clk_i;
    endcase
  end

  assign fixed_on_o = fixed_q;

  assert_square_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && wave_i == WAVE_SQUARE && !start_i) |=> $stable(sq_q));
  assert_run_low_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!sq_q && !half_q && !fixed_q));
endmodule

// File: rtl/pulse_cycle_gen.sv
module pulse_cycle_gen
  import pcg_pkg::*;
#(
  parameter int NUM_RANGES = 6,
  parameter int MULT_W     = 10,
  parameter int RSEL_W     = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  run_i,
  input  logic [1:0]            wave_i,
  input  logic                  free_i,
  input  logic                  gated_i,
  input  logic                  delayed_i,
  input  logic                  double_i,
  input  logic [RSEL_W-1:0]     pri_rng_i,
  input  logic [RSEL_W-1:0]     pw_rng_i,
  input  logic [MULT_W-1:0]     pri_mult_i,
  input  logic [MULT_W-1:0]     dly_mult_i,
  input  logic [MULT_W-1:0]     pw_mult_i,
  input  logic [NUM_RANGES-1:0] tick_i,
  input  logic                  trig_i,
  output logic                  pulse_o,
  output logic                  mark_o,
  output logic                  busy_o
);
  wave_e wave_w;
  logic  pri_tick_w, pw_tick_w;
  logic  seq_en_w, pulse_en_w;
  logic  want_w, start_w, active_w, dly_hit_w;
  logic  shaped_w, fixed_on_w;

  assign wave_w     = wave_e'(wave_i);
  assign seq_en_w   = run_i & ~wave_i[1];
  assign pulse_en_w = run_i & (wave_w == WAVE_PULSE);

  // range code n selects strobe n; codes past the table select nothing
  always_comb begin
    pri_tick_w = 1'b0;
    pw_tick_w  = 1'b0;
    for (int i = 0; i < NUM_RANGES; i++) begin
      if (pri_rng_i == RSEL_W'(i)) pri_tick_w = tick_i[i];
      if (pw_rng_i  == RSEL_W'(i)) pw_tick_w  = tick_i[i];
    end
  end

  pcg_start_qual u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .free_i (free_i),
    .gated_i(gated_i),
    .trig_i (trig_i),
    .want_o (want_w)
  );

  pcg_interval_seq #(.MULT_W(MULT_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (seq_en_w),
    .want_i    (want_w),
    .tick_i    (pri_tick_w),
    .pri_mult_i(pri_mult_i),
    .dly_mult_i(dly_mult_i),
    .dly_en_i  (delayed_i | double_i),
    .start_o   (start_w),
    .active_o  (active_w),
    .dly_hit_o (dly_hit_w)
  );

  pcg_pulse_shaper #(.MULT_W(MULT_W)) u_shape (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pulse_en_i(pulse_en_w),
    .mark_en_i (seq_en_w),
    .start_i   (start_w),
    .prim_en_i (~delayed_i | double_i),
    .dly_hit_i (dly_hit_w & pulse_en_w),
    .tick_i    (pw_tick_w),
    .pw_mult_i (pw_mult_i),
    .pulse_o   (shaped_w),
    .mark_o    (mark_o)
  );

  pcg_wave_out u_wave (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .wave_i    (wave_w),
    .start_i   (start_w),
    .pulse_i   (shaped_w),
    .fixed_on_o(fixed_on_w),
    .pulse_o   (pulse_o)
  );

  assign busy_o = active_w | fixed_on_w;
endmodule

// File: tb/pulse_cycle_gen_tb_top.sv
module pulse_cycle_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 6;
  localparam int PRI = 6;
  localparam int DLY = 3;
  localparam int PW = 2;

  typedef struct {
    logic  p;
    logic  m;
    logic  b;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, free_r = 0, gated = 0, delayed = 0, dbl = 0, trig = 0;
  logic [1:0] wave = 2'b00;
  logic [2:0] pri_rng = 3'd0, pw_rng = 3'd0;
  logic [9:0] pri_mult = 10'(PRI), dly_mult = 10'(DLY), pw_mult = 10'(PW);
  logic [NR-1:0] tick = '1;
  logic pulse, mark, busy;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_cycle_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .wave_i(wave),
    .free_i(free_r), .gated_i(gated), .delayed_i(delayed), .double_i(dbl),
    .pri_rng_i(pri_rng), .pw_rng_i(pw_rng), .pri_mult_i(pri_mult),
    .dly_mult_i(dly_mult), .pw_mult_i(pw_mult), .tick_i(tick),
    .trig_i(trig), .pulse_o(pulse), .mark_o(mark), .busy_o(busy)
  );

  task automatic check_bits(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s pulse/mark/busy actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(logic p, logic m, logic b, string req);
    exp_t e;
    e.p = p; e.m = m; e.b = b; e.req = req;
    exp_q.push_back(e);
  endtask

  function automatic logic ref_pulse(int k, bit dl, bit db);
    int ph = k % PRI;
    return ((!dl || db) && ph < PW) || ((dl || db) && ph >= DLY && ph < DLY + PW);
  endfunction

  // stop the run, expect quiet outputs, and wiggle the trigger meanwhile (R11)
  task automatic stop_run();
    @(negedge clk);
    run = 0;
    for (int k = 0; k < 4; k++) push(0, 0, 0, "R11");
    repeat (3) begin
      @(negedge clk);
      trig = ~trig;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    trig = 0;
    free_r = 0; gated = 0; delayed = 0; dbl = 0; wave = 2'b00;
  endtask

  // monitor: one expected sample per rising edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check_bits(e.req, {pulse, mark, busy}, {e.p, e.m, e.b});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_bits("R1", {pulse, mark, busy}, 3'b000);

    // R2 and R5: free-running single pulse, trigger toggling has no effect
    @(negedge clk);
    free_r = 1; run = 1;
    for (int k = 0; k < 18; k++) push(ref_pulse(k, 0, 0), (k % PRI) == 0, 1, "R2/R5");
    repeat (17) begin
      @(negedge clk);
      trig = ~trig;
    end
    wait (exp_q.size() == 0);
    stop_run();

    // R3: delayed pulse only
    @(negedge clk);
    free_r = 1; delayed = 1; run = 1;
    for (int k = 0; k < 12; k++) push(ref_pulse(k, 1, 0), (k % PRI) == 0, 1, "R3");
    wait (exp_q.size() == 0);
    stop_run();

    // R4: double overrides delayed
    @(negedge clk);
    free_r = 1; delayed = 1; dbl = 1; run = 1;
    for (int k = 0; k < 12; k++) push(ref_pulse(k, 1, 1), (k % PRI) == 0, 1, "R4");
    wait (exp_q.size() == 0);
    stop_run();

    // R6: idle with run and no edge, then one edge gives one cycle; R7: mid-cycle edge ignored
    @(negedge clk);
    run = 1;
    push(0, 0, 0, "R6"); push(0, 0, 0, "R6");
    wait (exp_q.size() == 0);
    @(negedge clk);
    trig = 1;
    for (int k = 0; k < 10; k++)
      if (k < PRI) push(ref_pulse(k, 0, 0), k == 0, 1, "R6/R7");
      else         push(0, 0, 0, "R6/R7");
    @(negedge clk); trig = 0;
    @(negedge clk);
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
    wait (exp_q.size() == 0);
    stop_run();

    // R8: gate seen low first at edge index 8, so two cycles complete
    @(negedge clk);
    gated = 1; trig = 1; run = 1;
    for (int k = 0; k < 16; k++)
      if (k < 2*PRI) push(ref_pulse(k, 0, 0), (k % PRI) == 0, 1, "R8");
      else           push(0, 0, 0, "R8");
    repeat (8) @(negedge clk);
    trig = 0;
    wait (exp_q.size() == 0);
    stop_run();

    // R9: square per interval, delay setting ignored, level held after gate drop
    @(negedge clk);
    wave = 2'b01; gated = 1; delayed = 1; trig = 1; run = 1;
    for (int k = 0; k < 24; k++)
      if (k < 3*PRI) push(((k / PRI) % 2) == 0, (k % PRI) == 0, 1, "R9");
      else           push(1, 0, 0, "R9");
    repeat (14) @(negedge clk);
    trig = 0;
    wait (exp_q.size() == 0);
    stop_run();

    // R10: half-rate square
    @(negedge clk);
    wave = 2'b10; free_r = 1; run = 1;
    for (int k = 0; k < 8; k++) push((k % 2) == 0, 0, 1, "R10");
    wait (exp_q.size() == 0);
    stop_run();

    // R10: full-rate square, high phase via monitor and low phase here
    @(negedge clk);
    wave = 2'b11; run = 1;
    for (int k = 0; k < 6; k++) push(1, 0, 1, "R10");
    wait (exp_q.size() == 0);
    @(negedge clk);
    #(CLK_PERIOD/4);
    check_bits("R10", {pulse, mark, busy}, 3'b001);
    stop_run();

    // R12: width range strobe held low, so pulse and marker never end
    @(negedge clk);
    tick = 6'b111101; pw_rng = 3'd1; free_r = 1; run = 1;
    for (int k = 0; k < 10; k++) push(1, 1, 1, "R12");
    wait (exp_q.size() == 0);
    stop_run();
    tick = '1; pw_rng = 3'd0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule